// File: doc/BRIEF.md
# Register-Memory Add Sequencer

This block is a multicycle control and datapath slice for a single register-memory add instruction. A 16-bit instruction word is presented with a one-cycle start strobe. When the opcode matches, the block works through a fixed sequence:

1. It reads two registers through an external register-file port.
2. It issues a word-aligned memory read at the address held in the first source register and holds that request until memory signals ready.
3. It adds the loaded word to either the second source register or a sign-extended 5-bit immediate.
4. It writes the sum to the destination register and updates the negative/zero/positive flags.
5. It pulses done.

Both register operands are captured before anything is written. An instruction that names one register as both sources and the destination therefore computes from the old value. Memory latency is not fixed inside the block. It waits on the ready handshake, so a memory that answers in five cycles or any other count works unchanged. Instruction fetch and all other opcodes belong to the surrounding processor.

Top module: `memadd_exec`

## Requirements
- R1: While reset is held and in the cycle after it, done, mem_req and rf_we are 0, and the flags read N=0, Z=1, P=0.
- R2: A start pulse is accepted only when instr[15:12] equals 4'b1010. A start with any other value there causes no memory request, no register write, no done and no flag change.
- R3: The memory address is the value of the register named by instr[8:6] with bit 0 forced to 0. mem_req stays high with mem_addr stable until a cycle in which mem_ready is 1, and drops in the following cycle.
- R4: When instr[5] is 0, the result is the loaded memory word plus the register named by instr[2:0].
- R5: When instr[5] is 1, the result is the loaded memory word plus instr[4:0] sign-extended to 16 bits.
- R6: Each accepted instruction produces exactly one rf_we pulse, one cycle long, with rf_waddr equal to instr[11:9].
- R7: With the write, exactly one flag is set: N when result bit 15 is 1, Z when the result is 0, and P otherwise. The flags change only in the cycle in which rf_we rises.
- R8: When instr[11:9], instr[8:6] and instr[2:0] all name the same register, the result is computed from that register's value before the write.
- R9: done is a one-cycle pulse in the cycle right after the rf_we pulse. A start pulse that arrives while an instruction is in progress is ignored.
- R10: The addition wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe qualifying instr |
| instr | input | 16 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr_a | output | 3 | Register-file read address for the address source |
| rf_raddr_b | output | 3 | Register-file read address for the second source |
| rf_rdata_a | input | 16 | Read data for rf_raddr_a (combinational) |
| rf_rdata_b | input | 16 | Read data for rf_raddr_b (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write address |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory read request, held until ready |
| mem_addr | output | 16 | Word-aligned memory read address |
| mem_ready | input | 1 | Memory read data valid this cycle |
| mem_rdata | input | 16 | Memory read data |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_p | output | 1 | Positive flag |

## Verification
The bench sets all three register fields to one register. A design that read its operands after the write, or that forwarded the new value, would double-count and miss the expected sum. It places an odd value in the address register, which exposes a design that passes bit 0 through to memory. It uses immediates at both ends of the 5-bit range and a memory word that wraps to zero, which catches zero-extension of the immediate, a wrong flag on a zero or negative result, and a carry leaking into the result. It also sends a foreign opcode and a second start during a busy instruction. A design that decoded too loosely, or that restarted mid-sequence, would issue an extra request or write.

// File: rtl/memadd_pkg.sv
package memadd_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam logic [OPC_W-1:0] OPC_MEMADD = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREG,
    ST_MWAIT,
    ST_EXEC,
    ST_FIN
  } state_t;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  localparam cc_t CC_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

endpackage

// File: rtl/memadd_decode.sv
module memadd_decode #(
  parameter int DATA_W  = 16,
  parameter int RADDR_W = 3,
  parameter int IMM_W   = 5,
  localparam int FIELD_W = IMM_W + 1 + 2 * RADDR_W
) (
  input  logic [FIELD_W-1:0] fields,
  output logic [RADDR_W-1:0] dst,
  output logic [RADDR_W-1:0] src_addr,
  output logic [RADDR_W-1:0] src_reg,
  output logic               use_imm,
  output logic [DATA_W-1:0]  imm_ext
);

  localparam int MODE_POS = IMM_W;
  localparam int SRCA_LSB = IMM_W + 1;
  localparam int DST_LSB  = SRCA_LSB + RADDR_W;

  logic [IMM_W-1:0] imm_raw;

  always_comb begin
    dst      = fields[DST_LSB +: RADDR_W];
    src_addr = fields[SRCA_LSB +: RADDR_W];
    src_reg  = fields[RADDR_W-1:0];
    use_imm  = fields[MODE_POS];
    imm_raw  = fields[IMM_W-1:0];
    imm_ext  = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};
  end

endmodule

// File: rtl/memadd_result.sv
module memadd_result
  import memadd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] mem_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] sum,
  output cc_t               cc_next
);

  always_comb begin
    sum       = mem_word + operand;
    cc_next.n = sum[DATA_W-1];
    cc_next.z = (sum == '0);
    cc_next.p = !sum[DATA_W-1] && (sum != '0);
  end

endmodule

// File: rtl/memadd_exec.sv
module memadd_exec
  import memadd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RADDR_W = 3,
  parameter int IMM_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [15:0]        instr,
  output logic               done,
  output logic [RADDR_W-1:0] rf_raddr_a,
  output logic [RADDR_W-1:0] rf_raddr_b,
  input  logic [DATA_W-1:0]  rf_rdata_a,
  input  logic [DATA_W-1:0]  rf_rdata_b,
  output logic               rf_we,
  output logic [RADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               mem_req,
  output logic [DATA_W-1:0]  mem_addr,
  input  logic               mem_ready,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               cc_n,
  output logic               cc_z,
  output logic               cc_p
);

  localparam int FIELD_W = IMM_W + 1 + 2 * RADDR_W;
  localparam logic [DATA_W-1:0] ALIGN_MASK = {{(DATA_W-1){1'b1}}, 1'b0};

  state_t              state;
  logic [FIELD_W-1:0]  ir_q;
  logic [DATA_W-1:0]   opnd_q;
  logic [DATA_W-1:0]   mword_q;
  cc_t                 cc_q;

  logic [RADDR_W-1:0]  dec_dst;
  logic [RADDR_W-1:0]  dec_srca;
  logic [RADDR_W-1:0]  dec_srcr;
  logic                dec_use_imm;
  logic [DATA_W-1:0]   dec_imm;
  logic [DATA_W-1:0]   res_sum;
  cc_t                 res_cc;
  logic                accept;

  memadd_decode #(
    .DATA_W (DATA_W),
    .RADDR_W(RADDR_W),
    .IMM_W  (IMM_W)
  ) u_decode (
    .fields  (ir_q),
    .dst     (dec_dst),
    .src_addr(dec_srca),
    .src_reg (dec_srcr),
    .use_imm (dec_use_imm),
    .imm_ext (dec_imm)
  );

  memadd_result #(
    .DATA_W(DATA_W)
  ) u_result (
    .mem_word(mword_q),
    .operand (opnd_q),
    .sum     (res_sum),
    .cc_next (res_cc)
  );

  assign accept     = start && (instr[INSTR_W-1 -: OPC_W] == OPC_MEMADD);
  assign rf_raddr_a = dec_srca;
  assign rf_raddr_b = dec_srcr;
  assign cc_n       = cc_q.n;
  assign cc_z       = cc_q.z;
  assign cc_p       = cc_q.p;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ir_q     <= '0;
      opnd_q   <= '0;
      mword_q  <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      done     <= 1'b0;
      cc_q     <= CC_RESET;
    end else begin
      rf_we <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ir_q  <= instr[FIELD_W-1:0];
            state <= ST_RDREG;
          end
        end
        ST_RDREG: begin
          // both sources captured here, before any write
          opnd_q   <= dec_use_imm ? dec_imm : rf_rdata_b;
          mem_addr <= rf_rdata_a & ALIGN_MASK;
          mem_req  <= 1'b1;
          state    <= ST_MWAIT;
        end
        ST_MWAIT: begin
          if (mem_ready) begin
            mword_q <= mem_rdata;
            mem_req <= 1'b0;
            state   <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          rf_we    <= 1'b1;
          rf_waddr <= dec_dst;
          rf_wdata <= res_sum;
          cc_q     <= res_cc;
          state    <= ST_FIN;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/memadd_exec_chk.sv
module memadd_exec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              rf_we,
  input logic              mem_req,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              cc_n,
  input logic              cc_z,
  input logic              cc_p
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!done && !mem_req && !rf_we && !cc_n && cc_z && !cc_p));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req);

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we);

  // R7
  cc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({cc_n, cc_z, cc_p}) == 1);

  // R7
  cc_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({cc_n, cc_z, cc_p}) |-> $rose(rf_we));

  // R9
  done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(rf_we) && !rf_we && !mem_req));

endmodule

bind memadd_exec memadd_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .rf_we    (rf_we),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ready(mem_ready),
  .cc_n     (cc_n),
  .cc_z     (cc_z),
  .cc_p     (cc_p)
);

// File: tb/test_memadd_exec.sv
module test_memadd_exec;

  localparam int MEM_LAT = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        done;
  logic [2:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [15:0] rf_rdata_a, rf_rdata_b, rf_wdata;
  logic        rf_we, mem_req, mem_ready;
  logic [15:0] mem_addr, mem_rdata;
  logic        cc_n, cc_z, cc_p;

  logic [15:0] rf_m [8];
  logic [15:0] mem_m [256];
  int          lat_cnt = 0;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;

  memadd_exec i_memadd_exec (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .done(done),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p)
  );

  assign rf_rdata_a = rf_m[rf_raddr_a];
  assign rf_rdata_b = rf_m[rf_raddr_b];
  assign mem_rdata  = mem_m[mem_addr[8:1]];
  assign mem_ready  = mem_req && (lat_cnt == MEM_LAT - 1);

  always @(posedge clk) begin
    if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    if (mem_req && !mem_ready) lat_cnt <= lat_cnt + 1;
    else lat_cnt <= 0;
  end

  // {instr, address-register value, second-register value, memory word}
  localparam logic [63:0] VEC [6] = '{
    {16'hA443, 16'h0040, 16'h0005, 16'h0010},
    {16'hA1BD, 16'h0060, 16'h7777, 16'h0002},
    {16'hA3EF, 16'h00A2, 16'h1111, 16'hFFF1},
    {16'hA782, 16'h0060, 16'h0001, 16'h8000},
    {16'hA930, 16'h0081, 16'h2222, 16'h1234},
    {16'hAB45, 16'h0010, 16'h0010, 16'h0100}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] ins, input logic [15:0] a,
                           input logic [15:0] b, input logic [15:0] m,
                           input bit poke, input string tag);
    logic [15:0] expv, opnd, req_addr, wdata;
    logic [2:0]  waddr;
    logic [2:0]  exp_cc;
    bit          seen_req, got_done;
    int          n_wr, wr_c, done_c, n_req_starts;
    rf_m[ins[2:0]] = b;
    rf_m[ins[8:6]] = a;
    mem_m[a[8:1]]  = m;
    opnd = ins[5] ? {{11{ins[4]}}, ins[4:0]} : rf_m[ins[2:0]];
    expv = m + opnd;
    exp_cc = expv[15] ? 3'b100 : (expv == 16'h0) ? 3'b010 : 3'b001;
    @(negedge clk);
    start = 1'b1; instr = ins;
    @(negedge clk);
    start = 1'b0;
    seen_req = 0; got_done = 0; n_wr = 0; wr_c = -1; done_c = -1;
    n_req_starts = 0; req_addr = '0; waddr = '0; wdata = '0;
    for (int c = 0; c < 40 && !got_done; c++) begin
      if (poke && c == 2) begin start = 1'b1; instr = 16'hA000; end
      else start = 1'b0;
      if (mem_req && !seen_req) begin
        seen_req = 1; req_addr = mem_addr; n_req_starts++;
      end
      if (rf_we) begin n_wr++; wr_c = c; waddr = rf_waddr; wdata = rf_wdata; end
      if (done) begin got_done = 1; done_c = c; end
      @(negedge clk);
    end
    start = 1'b0;
    // R9: watch a few more cycles for a stray second instruction
    for (int c = 0; c < 12; c++) begin
      if (rf_we) n_wr++;
      if (mem_req && !seen_req) n_req_starts++;
      @(negedge clk);
    end
    chk(req_addr == {a[15:1], 1'b0}, "R3", {tag, " mem address"}, req_addr, {a[15:1], 1'b0});
    chk(n_wr == 1, "R6", {tag, " write count"}, 16'(n_wr), 16'd1);
    chk(waddr == ins[11:9], "R6", {tag, " write address"}, 16'(waddr), 16'(ins[11:9]));
    chk(wdata == expv, tag, "result", wdata, expv);
    chk({cc_n, cc_z, cc_p} == exp_cc, "R7", {tag, " flags"}, 16'({cc_n, cc_z, cc_p}), 16'(exp_cc));
    chk(got_done && done_c == wr_c + 1, "R9", {tag, " done one cycle after write"},
        16'(done_c), 16'(wr_c + 1));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf_m[i] = '0;
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!done && !mem_req && !rf_we, "R1", "outputs idle after reset",
        16'({done, mem_req, rf_we}), 16'h0);
    chk({cc_n, cc_z, cc_p} == 3'b010, "R1", "reset flags", 16'({cc_n, cc_z, cc_p}), 16'h2);

    for (int i = 0; i < 6; i++) begin
      string tag;
      tag = VEC[i][53] ? "R5" : "R4";
      if (i == 2) tag = "R10";
      if (i == 5) tag = "R8";
      run_instr(VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0, tag);
    end
    // R8: the shared register now holds old value plus loaded word
    chk(rf_m[5] == 16'h0110, "R8", "shared register content", rf_m[5], 16'h0110);

    // R9: second start while busy is ignored
    run_instr(16'hA443, 16'h0040, 16'h0009, 16'h0020, 1'b1, "R4");

    // R2: foreign opcode
    begin
      int n_act;
      logic [2:0] cc_before;
      cc_before = {cc_n, cc_z, cc_p};
      n_act = 0;
      @(negedge clk);
      start = 1'b1; instr = 16'h1443;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 20; c++) begin
        if (mem_req || rf_we || done) n_act++;
        @(negedge clk);
      end
      chk(n_act == 0, "R2", "foreign opcode activity", 16'(n_act), 16'h0);
      chk({cc_n, cc_z, cc_p} == cc_before, "R2", "foreign opcode flags",
          16'({cc_n, cc_z, cc_p}), 16'(cc_before));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog (R9) actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule